// File: doc/BRIEF.md
# Two-Register Stack Execute Unit

This block is the execute section of a small microcoded stack machine. Each microinstruction is one byte wide. The unit keeps the two uppermost stack values in dedicated registers: the top in `tos` and the next value in `nos`. Every deeper value sits in an on-chip stack memory. The same memory also holds sixteen scratch variables and sixteen read-only constants. Arithmetic and logic work only on the two registers. A push moves the old next value out to memory (a spill). A pop brings one value back in from memory (a fill).

The unit has a two-stage pipeline. In the first stage a byte arrives from the microcode store at address `upc`. That stage works out the stack-memory read address the instruction will need. It uses the stack pointer as it will stand once the instruction now executing has finished. The memory is read synchronously, so the operand is waiting when the instruction reaches the second stage. A fill therefore needs no forwarding path and no write-back stage. The memory passes through a value written in the same cycle, which covers a pop that directly follows a push.

Conditional branches test the top value for zero or non-zero and always pop it. The branch distance comes from a 32-entry table, indexed by five instruction bits. When a branch is taken, the byte already fetched behind it is discarded. A wait instruction holds the whole unit still while the memory side reports busy.

Top module: `stack_exec`

## Requirements
- R1: While reset is asserted, `tos`, `nos` and `upc` are all zero. The stack pointer, the scratch variables and the stack memory start at zero.
- R2: With no wait stall and no taken branch, `upc` rises by one on every clock. The byte fetched at address p takes effect on the second rising edge after `upc` equals p.
- R3: The push bytes all put a new value in `tos`, move the old `tos` into `nos`, and spill the old `nos` to memory. They are:
    - `1000_nnnn`: scratch variable n.
    - `1001_kkkk`: constant k.
    - `1010_0001`: the `mem_rdata` input.
    - Every other `1xxx_xxxx`: a copy of `tos`.
- R4: Byte `0001_0ooo` with ooo from 0 to 4 writes nos+tos, nos−tos, AND, OR or XOR, in that order, into `tos`. Any other `0001_xxxx`, and any `0011_xxxx`, is a drop. An ALU byte and a drop both refill `nos` from the stack.
- R5: Bit 7 sets the direction of the stack pointer: 1 moves it up (push), 0 moves it down (pop). Bytes `0000_xxxx` leave the stack unchanged. `0000_0001` is wait and every other one is a no-op.
- R6: A pop that directly follows a push gets back the value just spilled, without an inserted bubble.
- R7: `0010_nnnn` stores `tos` into scratch variable n and pops. A load of the same variable placed directly after it returns the stored value.
- R8: Constant k reads as (291·k + 65) mod 2^DATA_W. No instruction can write the constant area.
- R9: `01cx_xxxx` is a branch. It pops `tos` and tests the popped value: it is taken on non-zero when bit 5 is 1, and on zero when bit 5 is 0. The table entry for index i (bits 4:0) is i − 16. A taken branch jumps to its own address plus that offset and discards the byte fetched behind it.
- R10: While a wait is executing and `mem_busy` is high, `upc`, `tos` and `nos` hold their values. The wait completes on the first clock with `mem_busy` low.
- R11: The spill area is a ring of 2^STK_AW entries. Pushes past its size wrap and overwrite the oldest spilled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 8 | Microinstruction byte fetched at `upc` |
| mem_busy | input | 1 | Memory side busy; stalls a wait instruction |
| mem_rdata | input | DATA_W | Value pushed by the memory-load instruction |
| upc | output | UPC_W | Microcode fetch address |
| tos | output | DATA_W | Top-of-stack register |
| nos | output | DATA_W | Second stack element register |

## Verification
Two operations can land on the same memory word in the same cycle. One is the write done by the executing instruction: a spill after a push, or a scratch store. The other is the synchronous read for the next instruction: a fill for a pop, or a scratch load. The bench forces this on purpose:
- a push immediately followed by a drop;
- a store immediately followed by a load of the same variable.

It also relies on random back-to-back sequences, which produce such pairs many times. A bench-side stack model judges each run by comparing the final `tos` and `nos`. A stale read through the collision shows up as a wrong `nos` after the refill.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    localparam int VAR_N   = 16;
    localparam int CONST_N = 16;
    localparam int BR_N    = 32;

    typedef enum logic [3:0] {
        K_NOP, K_WAIT, K_ALU, K_DROP, K_STV, K_BR, K_LDV, K_LDC, K_DUP, K_LDM
    } kind_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3, OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        EM_RUN, EM_HOLD, EM_SQUASH
    } exec_mode_e;

    typedef struct packed {
        kind_e   kind;
        logic    grow;
        logic    moves;
        alu_op_e op;
        logic [4:0] idx;
        logic    br_nz;
    } uop_t;

    // value of read-only constant k
    function automatic int imm_value(input int k);
        return k * 291 + 65;
    endfunction

endpackage

// File: rtl/stk_decode.sv
`timescale 1ns/1ps
module stk_decode
    import stk_pkg::*;
(
    input  logic [7:0] code,
    output uop_t       uop
);
    always_comb begin
        uop.kind  = K_NOP;
        uop.grow  = code[7];
        uop.moves = code[7] | (code[6:4] != 3'b000);
        uop.op    = OP_ADD;
        uop.idx   = code[4:0];
        uop.br_nz = code[5];
        if (code[7]) begin
            unique case (code[6:4])
                3'b000:  uop.kind = K_LDV;
                3'b001:  uop.kind = K_LDC;
                default: uop.kind = (code == 8'hA1) ? K_LDM : K_DUP;
            endcase
        end else if (code[6]) begin
            uop.kind = K_BR;
        end else if (code[5]) begin
            uop.kind = code[4] ? K_DROP : K_STV;
        end else if (code[4]) begin
            if (!code[3] && (code[2:0] <= 3'd4)) begin
                uop.kind = K_ALU;
                uop.op   = alu_op_e'(code[2:0]);
            end else begin
                uop.kind = K_DROP;
            end
        end else begin
            uop.kind = (code == 8'h01) ? K_WAIT : K_NOP;
        end
    end
endmodule

// File: rtl/stk_addr.sv
`timescale 1ns/1ps
module stk_addr #(
    parameter int AW         = 6,
    parameter int STK_AW     = 5,
    parameter int CONST_BASE = 16,
    parameter int STK_BASE   = 32
) (
    input  logic [7:0]        code,
    input  logic [STK_AW-1:0] sp_next,
    output logic [AW-1:0]     raddr
);
    // read address for the byte in the fetch stage, one cycle ahead of use
    always_comb begin
        unique case (code[7:4])
            4'b1000: raddr = AW'(code[3:0]);
            4'b1001: raddr = AW'(CONST_BASE) + AW'(code[3:0]);
            default: raddr = AW'(STK_BASE) + AW'(sp_next);
        endcase
    end
endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] tos,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = nos + tos;
            OP_SUB:  res = nos - tos;
            OP_AND:  res = nos & tos;
            OP_OR:   res = nos | tos;
            OP_XOR:  res = nos ^ tos;
            default: res = tos;
        endcase
    end
endmodule

// File: rtl/stk_ram.sv
`timescale 1ns/1ps
module stk_ram
    import stk_pkg::*;
#(
    parameter int W        = 16,
    parameter int DEPTH    = 64,
    parameter int AW       = 6,
    parameter int CONST_LO = 16,
    parameter int CONST_HI = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW-1:0] LO_A = AW'(CONST_LO);
    localparam logic [AW-1:0] HI_A = AW'(CONST_HI);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i >= CONST_LO && i < CONST_HI) ? W'(imm_value(i - CONST_LO)) : '0;
            end
            rdata <= '0;
        end else if (en) begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            // write-first: a same-cycle write is visible to the read
            rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
        end
    end

    a_r8_const_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |-> (waddr < LO_A || waddr >= HI_A));
endmodule

// File: rtl/stack_exec.sv
`timescale 1ns/1ps
module stack_exec
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STK_AW = 5,
    parameter int UPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        instr,
    input  logic              mem_busy,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [UPC_W-1:0]  upc,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos
);
    localparam int CONST_BASE = VAR_N;
    localparam int STK_BASE   = VAR_N + CONST_N;
    localparam int DEPTH      = STK_BASE + (1 << STK_AW);
    localparam int AW         = $clog2(DEPTH);

    logic [7:0]        ir;
    logic [UPC_W-1:0]  ir_pc;
    logic [DATA_W-1:0] tos_q, nos_q, tos_nxt, nos_nxt, push_val, alu_res, rd_q;
    logic [STK_AW-1:0] sp, sp_inc, sp_after;
    logic [AW-1:0]     raddr, waddr;
    logic [DATA_W-1:0] wdata;
    logic              we, taken, en;
    logic [UPC_W-1:0]  br_target;
    uop_t              uop_x;
    exec_mode_e        mode;

    // branch distance table: entry i holds i - BR_N/2
    logic [UPC_W-1:0] br_tab [BR_N];
    for (genvar g = 0; g < BR_N; g++) begin : g_br
        assign br_tab[g] = UPC_W'(g) - UPC_W'(BR_N / 2);
    end

    stk_decode u_dec_x (.code(ir), .uop(uop_x));

    assign sp_inc   = sp + STK_AW'(1);
    assign sp_after = !uop_x.moves ? sp : (uop_x.grow ? sp_inc : sp - STK_AW'(1));

    stk_addr #(.AW(AW), .STK_AW(STK_AW), .CONST_BASE(CONST_BASE), .STK_BASE(STK_BASE))
        u_addr (.code(instr), .sp_next(sp_after), .raddr(raddr));

    assign we    = uop_x.grow || (uop_x.kind == K_STV);
    assign waddr = uop_x.grow ? AW'(STK_BASE) + AW'(sp_inc) : AW'(uop_x.idx[3:0]);
    assign wdata = uop_x.grow ? nos_q : tos_q;
    assign en    = (mode != EM_HOLD);

    stk_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CONST_LO(CONST_BASE), .CONST_HI(STK_BASE))
        u_ram (.clk(clk), .rst_n(rst_n), .en(en), .we(we), .waddr(waddr),
               .wdata(wdata), .raddr(raddr), .rdata(rd_q));

    stk_alu #(.W(DATA_W)) u_alu (.op(uop_x.op), .nos(nos_q), .tos(tos_q), .res(alu_res));

    assign taken     = (uop_x.kind == K_BR) && (uop_x.br_nz ? (tos_q != '0) : (tos_q == '0));
    assign br_target = ir_pc + br_tab[uop_x.idx];

    // mode of the current cycle
    always_comb begin
        if (uop_x.kind == K_WAIT && mem_busy) mode = EM_HOLD;
        else if (taken)                       mode = EM_SQUASH;
        else                                  mode = EM_RUN;
    end

    always_comb begin
        unique case (uop_x.kind)
            K_LDV, K_LDC: push_val = rd_q;
            K_LDM:        push_val = mem_rdata;
            default:      push_val = tos_q;
        endcase
        tos_nxt = tos_q;
        nos_nxt = nos_q;
        if (uop_x.grow) begin
            tos_nxt = push_val;
            nos_nxt = tos_q;
        end else if (uop_x.kind == K_ALU) begin
            tos_nxt = alu_res;
            nos_nxt = rd_q;
        end else if (uop_x.moves) begin
            tos_nxt = nos_q;
            nos_nxt = rd_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc   <= '0;
            ir    <= 8'h00;
            ir_pc <= '0;
            tos_q <= '0;
            nos_q <= '0;
            sp    <= '0;
        end else begin
            unique case (mode)
                EM_HOLD: begin
                end
                EM_SQUASH: begin
                    upc   <= br_target;
                    ir    <= 8'h00;
                    ir_pc <= upc;
                end
                EM_RUN: begin
                    upc   <= upc + UPC_W'(1);
                    ir    <= instr;
                    ir_pc <= upc;
                end
            endcase
            if (en) begin
                tos_q <= tos_nxt;
                nos_q <= nos_nxt;
                sp    <= sp_after;
            end
        end
    end

    assign tos = tos_q;
    assign nos = nos_q;

    a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_x.kind == K_WAIT && mem_busy) |=> ($stable(upc) && $stable(tos) && $stable(nos)));

    a_r3_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (en && uop_x.grow) |=> (nos == $past(tos)));

    a_r4_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (uop_x.kind == K_DROP || uop_x.kind == K_STV || uop_x.kind == K_BR))
        |=> (tos == $past(nos)));

    a_r9_squash: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (ir == 8'h00));

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EM_RUN) |=> (upc == UPC_W'($past(upc) + UPC_W'(1))));
endmodule

// File: tb/stack_exec_bench.sv
`timescale 1ns/1ps
module stack_exec_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_busy = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [7:0]    instr;
    logic [7:0]    upc;
    logic [DW-1:0] tos, nos;
    logic [7:0]    prog [256];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign instr = prog[upc];

    stack_exec u_stack_exec (
        .clk(clk), .rst_n(rst_n), .instr(instr), .mem_busy(mem_busy),
        .mem_rdata(mem_rdata), .upc(upc), .tos(tos), .nos(nos)
    );

    // reference stack model
    logic [DW-1:0] m_stk [32];
    logic [DW-1:0] m_var [16];
    int            m_sp;
    logic [DW-1:0] mA, mB;

    function automatic logic [DW-1:0] cval(input int k);
        return DW'(k * 291 + 65);
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 32; i++) m_stk[i] = '0;
        for (int i = 0; i < 16; i++) m_var[i] = '0;
        m_sp = 0; mA = '0; mB = '0;
    endfunction

    function automatic void m_push(input logic [DW-1:0] v);
        m_sp = (m_sp + 1) % 32;
        m_stk[m_sp] = mB;
        mB = mA;
        mA = v;
    endfunction

    function automatic void m_pop();
        mA = mB;
        mB = m_stk[m_sp];
        m_sp = (m_sp + 31) % 32;
    endfunction

    function automatic void m_step(input logic [7:0] c);
        logic [DW-1:0] r;
        if (c[7]) begin
            if (c[6:4] == 3'b000)      m_push(m_var[c[3:0]]);
            else if (c[6:4] == 3'b001) m_push(cval(int'(c[3:0])));
            else if (c == 8'hA1)       m_push(mem_rdata);
            else                       m_push(mA);
        end else if (c[5]) begin
            if (!c[4]) m_var[c[3:0]] = mA;
            m_pop();
        end else if (c[4]) begin
            if (!c[3] && c[2:0] <= 3'd4) begin
                case (c[2:0])
                    3'd0: r = mB + mA;
                    3'd1: r = mB - mA;
                    3'd2: r = mB & mA;
                    3'd3: r = mB | mA;
                    default: r = mB ^ mA;
                endcase
                m_pop();
                mA = r;
            end else begin
                m_pop();
            end
        end
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        m_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] c;
        void'($urandom(32'd4242));

        // R1: reset values, after activity
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h92;
        start();
        run(5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 tos", tos, '0);
        check("R1 nos", nos, '0);
        check("R1 upc", DW'(upc), '0);

        // R2: upc steps once per clock
        clear_prog();
        start();
        run(6);
        check("R2 upc", DW'(upc), DW'(6));

        // R5: push grows, pop shrinks, no-op leaves stack alone
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h92; prog[2] = 8'h18; prog[3] = 8'h00; prog[4] = 8'h93;
        start(); run(10);
        check("R5 tos", tos, cval(3));
        check("R5 nos", nos, cval(1));

        // R3: memory load pushes input
        clear_prog();
        mem_rdata = 16'hBEEF;
        prog[0] = 8'h94; prog[1] = 8'hA1;
        start(); run(8);
        check("R3 tos", tos, 16'hBEEF);
        check("R3 nos", nos, cval(4));

        // R4: subtract order
        clear_prog();
        prog[0] = 8'h95; prog[1] = 8'h92; prog[2] = 8'h11;
        start(); run(8);
        check("R4 sub", tos, cval(5) - cval(2));
        check("R4 refill", nos, '0);

        // R6: pops right after pushes
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h92; prog[2] = 8'h93; prog[3] = 8'h18; prog[4] = 8'h18;
        start(); run(10);
        check("R6 tos", tos, cval(1));
        check("R6 nos", nos, '0);

        // R7: store then load same variable
        clear_prog();
        prog[0] = 8'h93; prog[1] = 8'h23; prog[2] = 8'h83;
        start(); run(8);
        check("R7 tos", tos, cval(3));
        check("R7 nos", nos, '0);

        // R8: constants and no write through the drop alias
        for (int k = 0; k < 16; k++) begin
            clear_prog();
            prog[0] = 8'h90 | 8'(k); prog[1] = 8'h30 | 8'(k); prog[2] = 8'h90 | 8'(k);
            start(); run(7);
            check("R8 const", tos, cval(k));
        end

        // R9: forward taken branch discards the fetched byte
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h73; prog[2] = 8'h92; prog[3] = 8'h95; prog[4] = 8'h94;
        start(); run(12);
        check("R9 taken tos", tos, cval(4));
        check("R9 taken nos", nos, '0);

        // R9: not taken branch still pops
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h92; prog[2] = 8'h54; prog[3] = 8'h93;
        start(); run(10);
        check("R9 fall tos", tos, cval(3));
        check("R9 fall nos", nos, cval(1));

        // R9: backward branch loop runs twice
        clear_prog();
        prog[0] = 8'h85; prog[1] = 8'h75; prog[2] = 8'h93; prog[3] = 8'h25;
        prog[4] = 8'h80; prog[5] = 8'h4B; prog[6] = 8'h97;
        start(); run(30);
        check("R9 loop tos", tos, cval(7));
        check("R9 loop nos", nos, '0);

        // R10: wait held by busy
        clear_prog();
        prog[0] = 8'h91; prog[1] = 8'h01; prog[2] = 8'h92;
        mem_busy = 1'b1;
        start(); run(10);
        check("R10 upc held", DW'(upc), DW'(2));
        check("R10 tos held", tos, cval(1));
        mem_busy = 1'b0;
        run(1);
        check("R10 wait done", tos, cval(1));
        run(1);
        check("R10 resume", tos, cval(2));

        // R11: deep pushes wrap the spill ring
        clear_prog();
        start();
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            prog[i] = 8'h90 | 8'(i % 16); m_step(prog[i]);
        end
        for (int i = 40; i < 77; i++) begin
            prog[i] = 8'h18; m_step(prog[i]);
        end
        run(82);
        check("R11 tos", tos, mA);
        check("R11 nos", nos, mB);

        // R3 R4 R6 R7: random straight-line programs against the model
        for (int t = 0; t < 30; t++) begin
            clear_prog();
            mem_rdata = DW'($urandom);
            start();
            for (int i = 0; i < 40; i++) begin
                case ($urandom_range(0, 10))
                    0: c = 8'h80 | 8'($urandom_range(0, 15));
                    1: c = 8'h90 | 8'($urandom_range(0, 15));
                    2: c = ($urandom_range(0, 1) == 0) ? 8'hA0 : 8'hB5;
                    3: c = 8'hA1;
                    4: c = 8'h10 | 8'($urandom_range(0, 4));
                    5: c = 8'h18;
                    6: c = 8'h20 | 8'($urandom_range(0, 15));
                    7: c = 8'h00;
                    8: c = 8'h01;
                    9: c = 8'h30 | 8'($urandom_range(0, 15));
                    default: c = 8'h80 | 8'($urandom_range(0, 3));
                endcase
                prog[i] = c;
                m_step(c);
            end
            run(46);
            check("R4 random tos", tos, mA);
            check("R6 random nos", nos, mB);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule